// File: doc/BRIEF.md
# GPIO Pin Function and Output Register Core

This core owns the configuration and output state of a bank of general-purpose pins behind a plain 32-bit register bus. Every pin carries a 3-bit function code that decides whether the pad is a software-driven input, a software-driven output, or a pad handed to one of six peripheral functions. The core turns those codes into a per-pin output enable and a per-pin peripheral-select code. The peripherals, interrupt detection and pull configuration live elsewhere.

Software changes output levels through a pair of write-only strobe registers. One sets the bits written as one and the other clears them, so no read-modify-write is needed on the bus. The pad inputs pass through a synchronizer and can be read back one bit per pin. Function codes are packed ten to a word. The code-to-function map is deliberately non-linear: codes 4, 5, 6 and 7 select peripherals 0 to 3, code 3 selects peripheral 4 and code 2 selects peripheral 5.

Top module: `gpio_pinfunc_core`

## Requirements
- R1: While `rst` is high and after its release, every function code is 0 (input), every output latch is 0, `pad_oe` is all zero and `pad_fsel_alt` is all zero.
- R2: The function code of pin p is read and written at byte address 4*(p/10), bits [3*(p%10)+2 : 3*(p%10)]. Word addresses 0x00 through 0x14 hold function codes.
- R3: In function words, bits 31:30 read as zero. In word 0x14, only bits 11:0 (pins 50 to 53) exist and bits 31:12 read as zero. Writes to those bits are ignored.
- R4: Code 1 asserts `pad_oe` for the pin regardless of `periph_oe`. Code 0 deasserts it. For both codes, the pin's 3-bit field of `pad_fsel_alt` is 0.
- R5: Codes 2 through 7 place the code itself on the pin's field of `pad_fsel_alt` (bits [3p+2:3p]) and pass `periph_oe[p]` through to `pad_oe[p]`.
- R6: A write to 0x1C (pins 0 to 31) or 0x20 (pins 32 to 53) sets the output latch of every pin whose bit is 1 and leaves pins written with 0 unchanged. `pad_out` reflects the latch one clock after the write.
- R7: A write to 0x28 (pins 0 to 31) or 0x2C (pins 32 to 53) clears the output latch of every pin whose bit is 1 and leaves pins written with 0 unchanged.
- R8: The upper bank holds only 22 pins. Bits 31:22 of writes to 0x20 and 0x2C have no effect, and bits 31:22 of a read at 0x38 are zero.
- R9: A read of 0x34 returns pins 0 to 31 and a read of 0x38 returns pins 32 to 53, each after a two-flop synchronizer. `bus_rdata` is registered and valid in the cycle after `bus_rd`. A pad change made just before clock edge k first appears in a read strobed at edge k+2.
- R10: The set and clear addresses read as zero. Any unmapped or misaligned address (`bus_addr[1:0]` not 00) reads as zero, and a write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, zero when no read |
| pad_in | input | 54 | Raw pad input levels |
| periph_oe | input | 54 | Direction request from the selected peripheral |
| pad_out | output | 54 | Output latch values to the pads |
| pad_oe | output | 54 | Per-pin pad output enable |
| pad_fsel_alt | output | 162 | Per-pin peripheral select code, 3 bits per pin, 0 when software owns the pin |

## Verification
The properties assume that at most one write reaches the core per cycle and that `bus_wdata` is meaningful only while `bus_wr` is high. They also assume `periph_oe` may change at any time. This is why the output-enable checks only constrain pins whose enable is not explained by a peripheral request. The stimulus issues one access at a time, always separated by an idle cycle, except in the synchronizer latency test, which holds a single read strobe for three cycles. Pad and peripheral inputs are driven only on the falling edge.

// File: rtl/gpio_pinfunc_pkg.sv
package gpio_pinfunc_pkg;

    // Width of one per-pin function field.
    localparam int FIELD_W = 3;

    // Function codes. The peripheral numbering is not monotonic in the code.
    typedef enum logic [FIELD_W-1:0] {
        FUNC_INPUT   = 3'd0,
        FUNC_OUTPUT  = 3'd1,
        FUNC_PERIPH5 = 3'd2,
        FUNC_PERIPH4 = 3'd3,
        FUNC_PERIPH0 = 3'd4,
        FUNC_PERIPH1 = 3'd5,
        FUNC_PERIPH2 = 3'd6,
        FUNC_PERIPH3 = 3'd7
    } func_code_e;

    // Byte offsets of the register groups.
    localparam logic [7:0] OFS_FUNC  = 8'h00;
    localparam logic [7:0] OFS_SET   = 8'h1C;
    localparam logic [7:0] OFS_CLR   = 8'h28;
    localparam logic [7:0] OFS_LEVEL = 8'h34;

    // Kind of register an access targets.
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_FUNC,
        ACC_SET,
        ACC_CLR,
        ACC_LEVEL
    } acc_kind_e;

endpackage

// File: rtl/gpio_fsel_store.sv
module gpio_fsel_store
    import gpio_pinfunc_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int PER_WORD = 10,
    parameter int IDX_W    = 6
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      word_idx,
    input  logic [PER_WORD*FIELD_W-1:0]           wdata,
    output logic [PER_WORD*FIELD_W-1:0]           rd_word,
    output logic [NUM_PINS-1:0][FIELD_W-1:0]      codes
);

    typedef struct packed {
        logic [NUM_PINS-1:0][FIELD_W-1:0] code;
    } fsel_st_t;

    fsel_st_t st_d, st_q;

    // Next state: only fields that belong to the addressed word take new data.
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (int'(word_idx) == p / PER_WORD) begin
                    st_d.code[p] = wdata[FIELD_W*(p % PER_WORD) +: FIELD_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Readback: fields with no pin stay zero.
    always_comb begin
        rd_word = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(word_idx) == p / PER_WORD) begin
                rd_word[FIELD_W*(p % PER_WORD) +: FIELD_W] = st_q.code[p];
            end
        end
    end

    assign codes = st_q.code;

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
    parameter int NUM_PINS = 54,
    parameter int BUS_W    = 32,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    bank_idx,
    input  logic [BUS_W-1:0]    wdata,
    output logic [NUM_PINS-1:0] out_lvl
);

    typedef struct packed {
        logic [NUM_PINS-1:0] lvl;
    } out_st_t;

    out_st_t st_d, st_q;

    // Strobe registers: a one bit acts, a zero bit keeps the latch.
    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(bank_idx) == p / BUS_W && wdata[p % BUS_W]) begin
                if (set_en) begin
                    st_d.lvl[p] = 1'b1;
                end
                if (clr_en) begin
                    st_d.lvl[p] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_lvl = st_q.lvl;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 54,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] raw_in,
    output logic [NUM_PINS-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][NUM_PINS-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = raw_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stg[STAGES-1];

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_pinfunc_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic [NUM_PINS-1:0][FIELD_W-1:0] codes,
    input  logic [NUM_PINS-1:0]              periph_oe,
    output logic [NUM_PINS-1:0]              pad_oe,
    output logic [NUM_PINS-1:0][FIELD_W-1:0] pad_sel
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        always_comb begin
            case (func_code_e'(codes[g]))
                FUNC_INPUT: begin
                    pad_oe[g]  = 1'b0;
                    pad_sel[g] = '0;
                end
                FUNC_OUTPUT: begin
                    pad_oe[g]  = 1'b1;
                    pad_sel[g] = '0;
                end
                default: begin
                    pad_oe[g]  = periph_oe[g];
                    pad_sel[g] = codes[g];
                end
            endcase
        end
    end

endmodule

// File: rtl/gpio_pinfunc_core.sv
module gpio_pinfunc_core
    import gpio_pinfunc_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int BUS_W    = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BUS_W-1:0]              bus_wdata,
    output logic [BUS_W-1:0]              bus_rdata,
    input  logic [NUM_PINS-1:0]           pad_in,
    input  logic [NUM_PINS-1:0]           periph_oe,
    output logic [NUM_PINS-1:0]           pad_out,
    output logic [NUM_PINS-1:0]           pad_oe,
    output logic [NUM_PINS*FIELD_W-1:0]   pad_fsel_alt
);

    localparam int PER_WORD   = BUS_W / FIELD_W;
    localparam int FUNC_WORDS = (NUM_PINS + PER_WORD - 1) / PER_WORD;
    localparam int NUM_BANKS  = (NUM_PINS + BUS_W - 1) / BUS_W;
    localparam int IDX_W      = ADDR_W - 2;
    localparam int FUNC_IDX   = int'(OFS_FUNC) / 4;
    localparam int SET_IDX    = int'(OFS_SET) / 4;
    localparam int CLR_IDX    = int'(OFS_CLR) / 4;
    localparam int LEVEL_IDX  = int'(OFS_LEVEL) / 4;
    localparam int SYNC_STAGES = 2;

    // Address decode.
    acc_kind_e          acc;
    logic [IDX_W-1:0]   sub_idx;
    logic [IDX_W-1:0]   word_idx;

    assign word_idx = bus_addr[ADDR_W-1:2];

    always_comb begin
        acc     = ACC_NONE;
        sub_idx = '0;
        if (bus_addr[1:0] == 2'b00) begin
            if (int'(word_idx) >= FUNC_IDX && int'(word_idx) < FUNC_IDX + FUNC_WORDS) begin
                acc     = ACC_FUNC;
                sub_idx = word_idx - IDX_W'(FUNC_IDX);
            end else if (int'(word_idx) >= SET_IDX && int'(word_idx) < SET_IDX + NUM_BANKS) begin
                acc     = ACC_SET;
                sub_idx = word_idx - IDX_W'(SET_IDX);
            end else if (int'(word_idx) >= CLR_IDX && int'(word_idx) < CLR_IDX + NUM_BANKS) begin
                acc     = ACC_CLR;
                sub_idx = word_idx - IDX_W'(CLR_IDX);
            end else if (int'(word_idx) >= LEVEL_IDX && int'(word_idx) < LEVEL_IDX + NUM_BANKS) begin
                acc     = ACC_LEVEL;
                sub_idx = word_idx - IDX_W'(LEVEL_IDX);
            end
        end
    end

    // Function-select storage.
    logic [PER_WORD*FIELD_W-1:0]        func_rd;
    logic [NUM_PINS-1:0][FIELD_W-1:0]   codes;

    gpio_fsel_store #(
        .NUM_PINS (NUM_PINS),
        .PER_WORD (PER_WORD),
        .IDX_W    (IDX_W)
    ) fsel_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr && acc == ACC_FUNC),
        .word_idx (sub_idx),
        .wdata    (bus_wdata[PER_WORD*FIELD_W-1:0]),
        .rd_word  (func_rd),
        .codes    (codes)
    );

    // Output latches.
    gpio_out_latch #(
        .NUM_PINS (NUM_PINS),
        .BUS_W    (BUS_W),
        .IDX_W    (IDX_W)
    ) outl_i (
        .clk      (clk),
        .rst      (rst),
        .set_en   (bus_wr && acc == ACC_SET),
        .clr_en   (bus_wr && acc == ACC_CLR),
        .bank_idx (sub_idx),
        .wdata    (bus_wdata),
        .out_lvl  (pad_out)
    );

    // Input synchronizer.
    logic [NUM_PINS-1:0] sync_lvl;

    gpio_in_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pad_in),
        .sync_out (sync_lvl)
    );

    // Pad control.
    logic [NUM_PINS-1:0][FIELD_W-1:0] pad_sel;

    gpio_pad_drive #(
        .NUM_PINS (NUM_PINS)
    ) drive_i (
        .codes     (codes),
        .periph_oe (periph_oe),
        .pad_oe    (pad_oe),
        .pad_sel   (pad_sel)
    );

    assign pad_fsel_alt = pad_sel;

    // Registered read path.
    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (bus_rd) begin
            case (acc)
                ACC_FUNC: begin
                    rd_d.rdata = BUS_W'(func_rd);
                end
                ACC_LEVEL: begin
                    for (int p = 0; p < NUM_PINS; p++) begin
                        if (int'(sub_idx) == p / BUS_W) begin
                            rd_d.rdata[p % BUS_W] = sync_lvl[p];
                        end
                    end
                end
                default: begin
                    rd_d.rdata = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

endmodule

// File: rtl/gpio_pinfunc_core_chk.sv
module gpio_pinfunc_core_chk
    import gpio_pinfunc_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int BUS_W    = 32,
    parameter int ADDR_W   = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [BUS_W-1:0]            bus_wdata,
    input logic [NUM_PINS-1:0]         periph_oe,
    input logic [NUM_PINS-1:0]         pad_out,
    input logic [NUM_PINS-1:0]         pad_oe,
    input logic [NUM_PINS*FIELD_W-1:0] pad_fsel_alt
);

    logic rst_prev = 1'b0;

    always_ff @(posedge clk) begin
        rst_prev <= rst;
    end

    // R1: one cycle after a reset edge the pads are quiet.
    always @(negedge clk) begin
        if (rst_prev) begin
            assert_reset_quiet_R1: assert (pad_out == '0 && pad_oe == '0 && pad_fsel_alt == '0)
                else $error("pads not quiet after reset");
        end
    end

    // R2: without a write, the pad function selection cannot move.
    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(pad_fsel_alt));

    // R6: a set strobe on pin 0 drives it high on the next cycle.
    assert_set_takes_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_SET) && bus_wdata[0]) |=> pad_out[0]);

    // R7: a clear strobe on pin 0 drives it low on the next cycle.
    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR) && bus_wdata[0]) |=> !pad_out[0]);

    // R6, R7: output latches hold while the bus is idle.
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(pad_out));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
        // R4: an enable not requested by a peripheral belongs to a software output.
        assert_oe_source_R4: assert property (@(posedge clk) disable iff (rst)
            (pad_oe[g] && !periph_oe[g]) |-> pad_fsel_alt[FIELD_W*g +: FIELD_W] == '0);
        // R5: a pin handed to a peripheral follows the peripheral's direction.
        assert_periph_dir_R5: assert property (@(posedge clk) disable iff (rst)
            (pad_fsel_alt[FIELD_W*g +: FIELD_W] != '0) |-> pad_oe[g] == periph_oe[g]);
    end

endmodule

bind gpio_pinfunc_core gpio_pinfunc_core_chk #(
    .NUM_PINS (NUM_PINS),
    .BUS_W    (BUS_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .periph_oe    (periph_oe),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .pad_fsel_alt (pad_fsel_alt)
);

// File: tb/gpio_pinfunc_core_tb_top.sv
module gpio_pinfunc_core_tb_top;

    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] periph_oe = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP*3-1:0] pad_fsel_alt;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_pinfunc_core dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad_in       (pad_in),
        .periph_oe    (periph_oe),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .pad_fsel_alt (pad_fsel_alt)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    function automatic logic [2:0] sel_of(input int pin);
        return pad_fsel_alt[3*pin +: 3];
    endfunction

    // Register access vectors: writes carry no expectation, reads are checked.
    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'h0,        32'h0,        4'd1},  // R1 reset value
        '{1'b0, 8'h14, 32'h0,        32'h0,        4'd1},  // R1
        '{1'b1, 8'h04, 32'hFFFFFFFF, 32'h0,        4'd3},
        '{1'b0, 8'h04, 32'h0,        32'h3FFFFFFF, 4'd3},  // R3 top two bits
        '{1'b1, 8'h14, 32'hFFFFFFFF, 32'h0,        4'd3},
        '{1'b0, 8'h14, 32'h0,        32'h00000FFF, 4'd3},  // R3 last word
        '{1'b1, 8'h14, 32'h0,        32'h0,        4'd2},
        '{1'b1, 8'h04, 32'h0,        32'h0,        4'd2},
        '{1'b0, 8'h04, 32'h0,        32'h0,        4'd2},  // R2
        '{1'b1, 8'h2C, 32'hFFFFFFFF, 32'h0,        4'd10},
        '{1'b0, 8'h2C, 32'h0,        32'h0,        4'd10}, // R10 clear reads 0
        '{1'b1, 8'h40, 32'hFFFFFFFF, 32'h0,        4'd10},
        '{1'b0, 8'h40, 32'h0,        32'h0,        4'd10}, // R10 unmapped
        '{1'b1, 8'h01, 32'hFFFFFFFF, 32'h0,        4'd10},
        '{1'b0, 8'h00, 32'h0,        32'h0,        4'd10}, // R10 misaligned ignored
        '{1'b1, 8'h08, 32'h00000200, 32'h0,        4'd2},  // pin 23 code 1
        '{1'b0, 8'h08, 32'h0,        32'h00000200, 4'd2},  // R2
        '{1'b1, 8'h10, 32'h00C00000, 32'h0,        4'd2},  // pin 47 code 6
        '{1'b0, 8'h10, 32'h0,        32'h00C00000, 4'd2}   // R2
    };

    initial begin
        #(4 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: pad state while in reset
        check("R1 out", 64'(pad_out), 64'h0);
        check("R1 oe", 64'(pad_oe), 64'h0);
        check("R1 sel", 64'(pad_fsel_alt[63:0]), 64'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(rd), 64'(VECS[i].exp));
            end
        end

        // R4: pin 23 is a software output, pin 47 is peripheral 2 with no request
        periph_oe = '0;
        @(negedge clk);
        check("R4 oe", 64'(pad_oe), 64'(54'd1 << 23));
        check("R4 sel23", 64'(sel_of(23)), 64'h0);
        check("R5 sel47", 64'(sel_of(47)), 64'h6);
        periph_oe = '1;
        @(negedge clk);
        check("R5 oe follows peripheral", 64'(pad_oe), 64'((54'd1 << 23) | (54'd1 << 47)));

        // R5: last word, pins 50..53 = codes 4, 2, 7, 0
        bus_write(8'h14, 32'h000001D4);
        check("R5 sel50", 64'(sel_of(50)), 64'h4);
        check("R5 sel51", 64'(sel_of(51)), 64'h2);
        check("R5 sel52", 64'(sel_of(52)), 64'h7);
        check("R5 sel53", 64'(sel_of(53)), 64'h0);
        check("R5 oe hi", 64'(pad_oe[53:50]), 64'h7);
        periph_oe = '0;
        @(negedge clk);
        check("R5 oe lo", 64'(pad_oe[53:50]), 64'h0);
        check("R4 oe kept", 64'(pad_oe[23]), 64'h1);

        // R6: set strobe
        bus_write(8'h1C, 32'h00800001);
        check("R6 set", 64'(pad_out), 64'h0000_0000_0080_0001);
        bus_write(8'h1C, 32'h0);
        check("R6 zero keeps", 64'(pad_out), 64'h0000_0000_0080_0001);
        // R8: upper bank set only has 22 pins
        bus_write(8'h20, 32'hFFFFFFFF);
        check("R8 set upper", 64'(pad_out), 64'h003F_FFFF_0080_0001);

        // R7: clear strobe
        bus_write(8'h28, 32'h00000001);
        check("R7 clear", 64'(pad_out), 64'h003F_FFFF_0080_0000);
        bus_write(8'h2C, 32'hFFC00001);
        check("R7 R8 clear upper", 64'(pad_out), 64'h003F_FFFE_0080_0000);
        bus_read(8'h1C, rd);
        check("R10 set reads zero", 64'(rd), 64'h0);

        // R9: level readback
        pad_in = 54'h2B_1234_89AB_CDEF;
        repeat (3) @(negedge clk);
        bus_read(8'h34, rd);
        check("R9 level low", 64'(rd), 64'h89ABCDEF);
        bus_read(8'h38, rd);
        check("R9 level high", 64'(rd), 64'h002B1234);
        pad_in = '1;
        repeat (3) @(negedge clk);
        bus_read(8'h38, rd);
        check("R8 level upper bits", 64'(rd), 64'h003FFFFF);

        // R9: synchronizer latency, read strobe held for three edges
        @(negedge clk);
        pad_in   = '0;
        bus_addr = 8'h34;
        bus_rd   = 1'b1;
        @(negedge clk);
        check("R9 edge k old", 64'(bus_rdata), 64'hFFFFFFFF);
        @(negedge clk);
        check("R9 edge k+1 old", 64'(bus_rdata), 64'hFFFFFFFF);
        @(negedge clk);
        check("R9 edge k+2 new", 64'(bus_rdata), 64'h0);
        bus_rd = 1'b0;
        @(negedge clk);
        check("R9 rdata idle", 64'(bus_rdata), 64'h0);

        // R1: reset in mid-run
        periph_oe = '1;
        rst = 1'b1;
        @(negedge clk);
        check("R1 out after reset", 64'(pad_out), 64'h0);
        check("R1 oe after reset", 64'(pad_oe), 64'h0);
        check("R1 sel after reset", 64'(pad_fsel_alt[161:100]), 64'h0);
        rst = 1'b0;
        bus_read(8'h14, rd);
        check("R1 func word after reset", 64'(rd), 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule